// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block runs the on-chip memory self-test. It decides whether a test runs, and it puts the test phases in order over several RAM arrays, one ROM and one translation-buffer RAM. A test starts in one of two ways. The first is an init request that is sampled while reset is held and acted on once reset is released. The second is a one-cycle run-BIST strobe from a test access port controller, which is accepted only after a previous test has completed. The memories themselves are not part of the block. The block drives their address, write-enable and write-data pins and reads their data back.

Phase one has two parts that run together. A March C sequence runs on every cache-style RAM array in parallel, with one comparator per array. At the same time, a 16-bit multiple-input signature register folds in every ROM word. When both parts have finished, phase two runs the same March C sequence on the translation-buffer array alone. The block shows busy, done, a per-memory failure vector and an overall pass. While it runs, it holds a snoop-lockout output high. Any inquire request that arrives during a run is recorded as a protocol violation.

Top module: `mbist_seq`

## Requirements
- R1: With `init` high at the last clock edge where synchronous reset `rst` is high, the first edge after reset is released starts a test, and `busy` is high from the next cycle.
- R2: With `init` low at that edge, no test runs. After the first edge past reset, `done` is 1 while `busy`, `pass` and `fail` are all 0.
- R3: A `run_bist` pulse starts a new test only while `done` is high. A pulse that arrives while `busy` is high changes neither the run length nor the result.
- R4: Phase one tests all `NARR` arrays in parallel. A read mismatch in array i sets the sticky bit `fail[i]`.
- R5: The March C order uses all-0 and all-1 backgrounds: ascending write 0; ascending read 0 then write 1; ascending read 1 then write 0; descending read 0 then write 1; descending read 1 then write 0; ascending read 0. This gives 5*2^AW array write cycles per run and catches a stuck-at-0 or stuck-at-1 bit in any cell.
- R6: The ROM signature starts at 0xFFFF. For each word w, from address 0 upwards, next = (s<<1) ^ (s[15] ? 0x1021 : 0) ^ w. `fail[NARR]` is set when the final value differs from `SIG_EXP`.
- R7: The translation-buffer March C (2^TW depth, 5*2^TW write cycles) starts only after phase one has ended, so no array write occurs once a translation-buffer write has been seen. A mismatch sets `fail[NARR+1]`.
- R8: `busy` stays high for exactly 10*2^AW + 10*2^TW + 1 cycles per run.
- R9: `snoop_block` is high exactly while `busy` is high. A `snoop_req` during `busy` sets `snoop_viol`, which stays set until the next launch. A `snoop_req` while idle does not set it.
- R10: `pass` equals `done` AND (a test ran) AND (all `fail` bits are 0). `done` stays high until the next launch or reset.
- R11: While in reset, `busy`, `done`, `pass`, `fail`, `snoop_block` and `snoop_viol` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init | input | 1 | Self-test request, sampled while reset is held |
| run_bist | input | 1 | One-cycle test strobe from the test access port |
| snoop_req | input | 1 | External inquire request |
| arr_addr | output | AW | Address shared by all cache arrays |
| arr_we | output | 1 | Write enable for all cache arrays |
| arr_wdata | output | DW | Background pattern written to the arrays |
| arr_rdata | input | NARR*DW | Read data, array i in slice i*DW |
| tlb_addr | output | TW | Translation-buffer address |
| tlb_we | output | 1 | Translation-buffer write enable |
| tlb_wdata | output | TDW | Translation-buffer background pattern |
| tlb_rdata | input | TDW | Translation-buffer read data |
| rom_addr | output | RW | ROM address |
| rom_rdata | input | 16 | ROM word |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished or skipped |
| pass | output | 1 | Test ran and found no failure |
| fail | output | NARR+2 | Per-array fail bits, then ROM, then translation buffer |
| snoop_block | output | 1 | Inquire lockout |
| snoop_viol | output | 1 | Inquire seen while busy |

## Verification
The assertions check on every cycle the properties that hold at all times:
- `busy` and `done` are never both high.
- No memory is written outside a run.
- The two write enables are never high together.
- Any write implies the lockout is high.
- `done` stays high while no strobe arrives.
- A passing result carries no fail bits.
- An inquire during a run raises the violation flag.
- Reset clears the status.

Only the bench scenarios can show the rest. Injected stuck-at faults in a first or last cell, or in either polarity, must land in the correct fail bit. A corrupted ROM word must change the signature. The run length must be exact. A mid-run strobe must be ignored. Skipping the test with init low, and relaunching from that state, must both work.

// File: rtl/mbist_seq.sv
`timescale 1ns/1ps
module mbist_seq #(
  parameter int NARR = 3,
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int TW = 3,
  parameter int TDW = 12,
  parameter int RW = 4,
  parameter logic [15:0] SIG_EXP = 16'h0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 init,
  input  logic                 run_bist,
  input  logic                 snoop_req,
  output logic [AW-1:0]        arr_addr,
  output logic                 arr_we,
  output logic [DW-1:0]        arr_wdata,
  input  logic [NARR*DW-1:0]   arr_rdata,
  output logic [TW-1:0]        tlb_addr,
  output logic                 tlb_we,
  output logic [TDW-1:0]       tlb_wdata,
  input  logic [TDW-1:0]       tlb_rdata,
  output logic [RW-1:0]        rom_addr,
  input  logic [15:0]          rom_rdata,
  output logic                 busy,
  output logic                 done,
  output logic                 pass,
  output logic [NARR+1:0]      fail,
  output logic                 snoop_block,
  output logic                 snoop_viol
);
  localparam int MAW = (AW > TW) ? AW : TW;
  localparam int NF = NARR + 2;

  typedef enum logic [1:0] {S_IDLE, S_PH1, S_PH2_TLB, S_DONE} st_t;

  st_t            st;
  logic           init_q, ran, mdone, rdone, op, viol;
  logic [2:0]     el;
  logic [MAW-1:0] a;
  logic [RW-1:0]  ra;
  logic [15:0]    sig;
  logic [NF-1:0]  fl;
  logic [NARR-1:0] amis;

  wire desc = (el == 3'd3) || (el == 3'd4);
  wire rdv  = (el == 3'd2) || (el == 3'd4);
  wire wrv  = (el == 3'd1) || (el == 3'd3);
  wire [MAW-1:0] last  = (st == S_PH1) ? MAW'({AW{1'b1}}) : MAW'({TW{1'b1}});
  wire [MAW-1:0] a_end = desc ? '0 : last;
  wire step_addr = op || (el == 3'd5);
  wire eng_on = (st == S_PH1 && !mdone) || st == S_PH2_TLB;
  wire launch = (st == S_IDLE && init_q) || (st == S_DONE && run_bist);
  wire [15:0] sig_nx = {sig[14:0], 1'b0} ^ (sig[15] ? 16'h1021 : 16'h0000) ^ rom_rdata;
  wire tmis = tlb_rdata != {TDW{rdv}};

  for (genvar i = 0; i < NARR; i++) begin : g_cmp
    assign amis[i] = arr_rdata[i*DW +: DW] != {DW{rdv}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; init_q <= init; ran <= 1'b0; mdone <= 1'b0; rdone <= 1'b0;
      op <= 1'b1; el <= '0; a <= '0; ra <= '0; sig <= 16'hFFFF; fl <= '0; viol <= 1'b0;
    end else begin
      if (busy && snoop_req) viol <= 1'b1;
      if (launch) begin
        st <= S_PH1; ran <= 1'b1; mdone <= 1'b0; rdone <= 1'b0; op <= 1'b1;
        el <= '0; a <= '0; ra <= '0; sig <= 16'hFFFF; fl <= '0; viol <= 1'b0;
      end else if (st == S_IDLE) begin
        st <= S_DONE;
      end else begin
        if (st == S_PH1 && !rdone) begin
          sig <= sig_nx;
          ra  <= ra + 1'b1;
          if (&ra) begin
            rdone    <= 1'b1;
            fl[NARR] <= sig_nx != SIG_EXP;
          end
        end
        if (eng_on) begin
          if (!op) begin
            if (st == S_PH1) fl[NARR-1:0] <= fl[NARR-1:0] | amis;
            else if (tmis) fl[NARR+1] <= 1'b1;
          end
          if (step_addr) begin
            if (a == a_end) begin
              if (el == 3'd5) begin
                if (st == S_PH1) mdone <= 1'b1;
                else st <= S_DONE;
              end else begin
                el <= el + 1'b1;
                a  <= (el == 3'd2 || el == 3'd3) ? last : '0;
                op <= 1'b0;
              end
            end else begin
              a  <= desc ? a - 1'b1 : a + 1'b1;
              op <= (el == 3'd0);
            end
          end else begin
            op <= 1'b1;
          end
        end
        if (st == S_PH1 && mdone && rdone) begin
          st <= S_PH2_TLB; el <= '0; a <= '0; op <= 1'b1;
        end
      end
    end
  end

  assign arr_addr    = a[AW-1:0];
  assign arr_we      = st == S_PH1 && !mdone && op;
  assign arr_wdata   = {DW{wrv}};
  assign tlb_addr    = a[TW-1:0];
  assign tlb_we      = st == S_PH2_TLB && op;
  assign tlb_wdata   = {TDW{wrv}};
  assign rom_addr    = ra;
  assign busy        = st == S_PH1 || st == S_PH2_TLB;
  assign done        = st == S_DONE;
  assign pass        = done && ran && !(|fl);
  assign fail        = fl;
  assign snoop_block = busy;
  assign snoop_viol  = viol;
endmodule

// File: rtl/mbist_seq_chk.sv
`timescale 1ns/1ps
module mbist_seq_chk #(
  parameter int NF = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          run_bist,
  input logic          snoop_req,
  input logic          arr_we,
  input logic          tlb_we,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic [NF-1:0] fail,
  input logic          snoop_block,
  input logic          snoop_viol
);
  p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (rst) !(busy && done));
  p_no_wr_idle_r7: assert property (@(posedge clk) disable iff (rst) !busy |-> (!arr_we && !tlb_we));
  p_phase_sep_r7: assert property (@(posedge clk) disable iff (rst) !(arr_we && tlb_we));
  p_wr_locked_r9: assert property (@(posedge clk) disable iff (rst) (arr_we || tlb_we) |-> snoop_block);
  p_done_hold_r10: assert property (@(posedge clk) disable iff (rst) (done && !run_bist) |=> done);
  p_pass_clean_r10: assert property (@(posedge clk) disable iff (rst) pass |-> (fail == '0));
  p_viol_set_r9: assert property (@(posedge clk) disable iff (rst) (busy && snoop_req) |=> snoop_viol);
  p_reset_state_r11: assert property (@(posedge clk) rst |=> (!busy && !done && !snoop_viol));
endmodule

bind mbist_seq mbist_seq_chk #(.NF(NARR + 2)) u_chk (
  .clk(clk), .rst(rst), .run_bist(run_bist), .snoop_req(snoop_req),
  .arr_we(arr_we), .tlb_we(tlb_we), .busy(busy), .done(done), .pass(pass),
  .fail(fail), .snoop_block(snoop_block), .snoop_viol(snoop_viol)
);

// File: tb/mbist_seq_tb_top.sv
`timescale 1ns/1ps
module mbist_seq_tb_top;
  localparam int NARR = 3, AW = 4, DW = 8, TW = 3, TDW = 12, RW = 4;
  localparam int AD = 1 << AW, TD = 1 << TW, RD = 1 << RW;

  function automatic logic [15:0] rom_word(int a);
    return 16'(a * 947) ^ 16'hA55A;
  endfunction

  function automatic logic [15:0] sig_of(int ca, logic [15:0] cm);
    logic [15:0] s = 16'hFFFF;
    for (int a = 0; a < RD; a++) begin
      logic [15:0] w = rom_word(a) ^ ((a == ca) ? cm : 16'h0000);
      s = {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0000) ^ w;
    end
    return s;
  endfunction

  localparam logic [15:0] SIGV = sig_of(-1, 16'h0000);

  logic clk, rst, init, run_bist, snoop_req;
  logic [AW-1:0] arr_addr; logic arr_we; logic [DW-1:0] arr_wdata; logic [NARR*DW-1:0] arr_rdata;
  logic [TW-1:0] tlb_addr; logic tlb_we; logic [TDW-1:0] tlb_wdata, tlb_rdata;
  logic [RW-1:0] rom_addr; logic [15:0] rom_rdata;
  logic busy, done, pass, snoop_block, snoop_viol; logic [NARR+1:0] fail;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  mbist_seq #(.NARR(NARR), .AW(AW), .DW(DW), .TW(TW), .TDW(TDW), .RW(RW), .SIG_EXP(SIGV)) dut_i (
    .clk(clk), .rst(rst), .init(init), .run_bist(run_bist), .snoop_req(snoop_req),
    .arr_addr(arr_addr), .arr_we(arr_we), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
    .tlb_addr(tlb_addr), .tlb_we(tlb_we), .tlb_wdata(tlb_wdata), .tlb_rdata(tlb_rdata),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .busy(busy), .done(done), .pass(pass),
    .fail(fail), .snoop_block(snoop_block), .snoop_viol(snoop_viol));

  logic [DW-1:0] am [NARR][AD], s1 [NARR][AD], s0 [NARR][AD];
  logic [TDW-1:0] tm [TD], ts1 [TD], ts0 [TD];
  int rc_a; logic [15:0] rc_m;

  always @(posedge clk) begin
    if (arr_we) for (int i = 0; i < NARR; i++) am[i][arr_addr] <= arr_wdata;
    if (tlb_we) tm[tlb_addr] <= tlb_wdata;
  end
  always_comb
    for (int i = 0; i < NARR; i++)
      arr_rdata[i*DW +: DW] = (am[i][arr_addr] | s1[i][arr_addr]) & ~s0[i][arr_addr];
  assign tlb_rdata = (tm[tlb_addr] | ts1[tlb_addr]) & ~ts0[tlb_addr];
  assign rom_rdata = rom_word(int'(rom_addr)) ^ ((int'(rom_addr) == rc_a) ? rc_m : 16'h0000);

  int checks = 0, errors = 0;
  int n_busy, n_aw, n_tw;
  bit saw_tlb, order_bad;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int i = 0; i < NARR; i++)
      for (int a = 0; a < AD; a++) begin s1[i][a] = '0; s0[i][a] = '0; end
    for (int a = 0; a < TD; a++) begin ts1[a] = '0; ts0[a] = '0; end
    rc_a = -1; rc_m = '0;
  endtask

  function automatic logic [NARR+1:0] exp_fail();
    logic [NARR+1:0] e = '0;
    for (int i = 0; i < NARR; i++)
      for (int a = 0; a < AD; a++) if (s1[i][a] != 0 || s0[i][a] != 0) e[i] = 1'b1;
    e[NARR] = sig_of(rc_a, rc_m) != SIGV;
    for (int a = 0; a < TD; a++) if (ts1[a] != 0 || ts0[a] != 0) e[NARR+1] = 1'b1;
    return e;
  endfunction

  task automatic tap();
    @(negedge clk) run_bist = 1'b1;
    @(negedge clk) run_bist = 1'b0;
  endtask

  task automatic wait_done(int strobe_at, int snoop_at);
    int guard = 0;
    n_busy = 0; n_aw = 0; n_tw = 0; saw_tlb = 0; order_bad = 0;
    while (!done && guard < 5000) begin
      if (busy) n_busy++;
      if (arr_we) begin n_aw++; if (saw_tlb) order_bad = 1; end
      if (tlb_we) begin n_tw++; saw_tlb = 1; end
      run_bist  = (n_busy == strobe_at);
      snoop_req = (n_busy == snoop_at);
      if (n_busy == snoop_at) check("R9 lockout high while busy", 64'(snoop_block), 64'd1);
      @(negedge clk);
      guard++;
    end
    run_bist = 1'b0; snoop_req = 1'b0;
    if (guard >= 5000) check("R8 run did not finish", 64'(done), 64'd1);
  endtask

  task automatic verify(string tag, bit exp_viol);
    logic [NARR+1:0] e = exp_fail();
    check({tag, " fail vector R4 R6 R7"}, 64'(fail), 64'(e));
    check({tag, " pass R10"}, 64'(pass), 64'(e == 0));
    check({tag, " busy length R8"}, 64'(n_busy), 64'(10*AD + 10*TD + 1));
    check({tag, " array writes R5"}, 64'(n_aw), 64'(5*AD));
    check({tag, " tlb writes R7"}, 64'(n_tw), 64'(5*TD));
    check({tag, " phase order R7"}, 64'(order_bad), 64'd0);
    check({tag, " snoop_viol R9"}, 64'(snoop_viol), 64'(exp_viol));
    check({tag, " lockout released R9"}, 64'(snoop_block), 64'd0);
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; init = 1'b1; run_bist = 1'b0; snoop_req = 1'b0;
    clear_faults();
    repeat (3) @(negedge clk);
    check("R11 reset busy", 64'(busy), 64'd0);
    check("R11 reset done", 64'(done), 64'd0);
    check("R11 reset pass/fail", 64'({pass, fail}), 64'd0);
    check("R11 reset snoop outputs", 64'({snoop_block, snoop_viol}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 boot launch busy", 64'(busy), 64'd1);
    wait_done(-1, -1);
    verify("R1 clean boot", 0);

    clear_faults(); s1[0][0] = 8'h01;
    tap(); check("R3 strobe launch", 64'(busy), 64'd1);
    wait_done(-1, -1); verify("R4 array0 first cell stuck1", 0);

    clear_faults(); s0[2][AD-1] = 8'h80;
    tap(); wait_done(-1, -1); verify("R4 array2 last cell stuck0", 0);

    clear_faults(); s0[1][5] = 8'h08;
    tap(); wait_done(-1, -1); verify("R5 read-one element catches stuck0", 0);

    clear_faults(); ts1[TD-1] = 12'h400;
    tap(); wait_done(-1, -1); verify("R7 tlb stuck1", 0);

    clear_faults(); rc_a = 9; rc_m = 16'h0004;
    tap(); wait_done(-1, -1); verify("R6 rom corruption", 0);

    clear_faults();
    tap(); wait_done(50, -1); verify("R3 strobe while busy ignored", 0);
    tap(); wait_done(200, -1); verify("R3 strobe in phase two ignored", 0);

    tap(); wait_done(-1, 30); verify("R9 snoop during run", 1);
    tap(); wait_done(-1, -1); verify("R9 violation cleared on launch", 0);

    repeat (20) @(negedge clk);
    check("R10 done holds", 64'(done), 64'd1);
    check("R10 pass holds", 64'(pass), 64'd1);
    snoop_req = 1'b1; @(negedge clk); snoop_req = 1'b0; @(negedge clk);
    check("R9 idle snoop not flagged", 64'(snoop_viol), 64'd0);

    for (int r = 0; r < 10; r++) begin
      clear_faults();
      for (int i = 0; i < NARR; i++)
        if ($urandom % 3 == 0) begin
          if ($urandom % 2 == 0) s1[i][$urandom % AD] = DW'(1) << ($urandom % DW);
          else s0[i][$urandom % AD] = DW'(1) << ($urandom % DW);
        end
      if ($urandom % 3 == 0) begin rc_a = int'($urandom % RD); rc_m = 16'(1) << ($urandom % 16); end
      if ($urandom % 3 == 0) ts0[$urandom % TD] = TDW'(1) << ($urandom % TDW);
      tap(); wait_done(-1, -1); verify("R4 random faults", 0);
    end

    rst = 1'b1; init = 1'b0; clear_faults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 skip done", 64'(done), 64'd1);
    check("R2 skip busy", 64'(busy), 64'd0);
    check("R2 skip pass/fail", 64'({pass, fail}), 64'd0);
    tap(); check("R3 launch after skip", 64'(busy), 64'd1);
    wait_done(-1, -1); verify("R3 run after skip", 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule